// File: doc/BRIEF.md
# Pulse-Counted Bidirectional Word Shifter

This block shifts an 8-bit word left or right by 0 to 7 positions. It does not use a single-pass barrel shifter. It moves the word one bit position per clock, and a counter for the chosen direction sets the number of moves. A load strobe captures the word and a 3-bit amount. The amount goes into either the left step generator or the right step generator, as the direction input selects. While its count is nonzero, that generator sends one single-position step per clock into a bidirectional shift register. When the count runs out, the shifted word is copied to a held parallel output and a one-cycle done pulse is raised.

The latency depends on the amount. An amount of N gives the result and done N+1 cycles after the load cycle. Vacated positions fill with zero, and bits pushed past either end are lost. A strobe that arrives while an operation is still running is dropped.

The controller has two states. IDLE waits for a load strobe. RUN lasts while steps are being issued and for one final cycle. The transitions are:
- ACCEPT (IDLE to RUN): a load strobe arrives in IDLE.
- STEP (RUN to RUN): the active generator still has a nonzero count.
- FINISH (RUN to IDLE): both counts are zero, so the result is registered and done pulses.

Top module: `pulse_shifter`

## Requirements
- R1: After reset, result is 0, done is 0 and busy is 0.
- R2: In IDLE, a load high on a rising edge is accepted. The word and amount are captured, and busy is 1 from the next cycle.
- R3: With dir = 0 (left, LSB toward MSB), the result equals (data << N) truncated to 8 bits.
- R4: With dir = 1 (right, MSB toward LSB), the result equals data >> N, with zeros filling from the MSB.
- R5: An amount of 0 returns the word unchanged, with done one cycle after the load cycle.
- R6: Done is high exactly N+1 cycles after the load cycle, and not earlier.
- R7: Done lasts a single cycle, and busy is 0 whenever done is 1.
- R8: A load strobe while busy is 1 is ignored. The running operation's result and timing are unaffected.
- R9: Result changes only in the cycle in which done is 1, and holds its value between operations.
- R10: Only the generator selected by dir counts. The other keeps a count of zero, so the register never receives a left step and a right step together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Load strobe for a new operation |
| data_in | input | 8 | Word to shift |
| amount | input | 3 | Number of single-bit steps, 0 to 7 |
| dir | input | 1 | 0 = left, 1 = right |
| result | output | 8 | Shifted word, held until the next result |
| done | output | 1 | One-cycle pulse when result is updated |
| busy | output | 1 | High while an operation is in progress |

## Verification
The assertions rely on only a few things about the inputs: the reset is applied before use, and load, data_in, amount and dir are stable around the rising edge. They do not require the strobe to be held off while the block is busy, because dropping such strobes is part of what is checked. The bench drives every input on the falling edge, so all of them settle half a period before the sampling edge.

Random words, amounts and directions from a fixed seed are mixed with directed cases. The directed cases cover amounts of 0 and 7, all-ones and single-bit words in both directions, and strobes issued in mid-operation. Each operation's outcome is predicted by a bench function.

// File: rtl/pulse_shifter_pkg.sv
package pulse_shifter_pkg;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctrl_state_e;

endpackage

// File: rtl/step_gen.sv
module step_gen #(
    parameter int AMT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic [AMT_W-1:0] amt,
    input  logic             enable,
    output logic             step,
    output logic [AMT_W-1:0] count
);

    assign step = enable && (count != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (arm) begin
            count <= amt;
        end else if (step) begin
            count <= count - 1'b1;
        end
    end

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !arm) |=> (count == $past(count) - 1'b1)); // R6

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !arm) |=> $stable(count)); // R10

endmodule

// File: rtl/bidir_shreg.sv
module bidir_shreg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] din,
    input  logic             step_left,
    input  logic             step_right,
    output logic [WIDTH-1:0] word
);

    logic [WIDTH-1:0] nxt;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        logic from_low;
        logic from_high;
        if (i == 0) begin : g_lsb
            assign from_low = 1'b0;
        end else begin : g_lo
            assign from_low = word[i-1];
        end
        if (i == WIDTH - 1) begin : g_msb
            assign from_high = 1'b0;
        end else begin : g_hi
            assign from_high = word[i+1];
        end
        always_comb begin
            if (load) begin
                nxt[i] = din[i];
            end else if (step_left) begin
                nxt[i] = from_low;
            end else if (step_right) begin
                nxt[i] = from_high;
            end else begin
                nxt[i] = word[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word <= '0;
        end else begin
            word <= nxt;
        end
    end

    AST_NO_DUAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_left && step_right)); // R10

    AST_LEFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_left && !load) |=> (word[0] == 1'b0)); // R3

    AST_RIGHT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_right && !load) |=> (word[WIDTH-1] == 1'b0)); // R4

endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             any_step,
    input  logic [WIDTH-1:0] word,
    output logic             accept,
    output logic             run,
    output logic             busy,
    output logic             done,
    output logic [WIDTH-1:0] result
);
    import pulse_shifter_pkg::*;

    ctrl_state_e state, state_nxt;
    logic        finish;

    assign run    = (state == ST_RUN);
    assign busy   = run;
    assign accept = (state == ST_IDLE) && load;
    assign finish = run && !any_step;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: if (load)      state_nxt = ST_RUN;
            ST_RUN:  if (!any_step) state_nxt = ST_IDLE;
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= finish;
            if (finish) begin
                result <= word;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R7

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy); // R2

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load) |-> !accept); // R8

endmodule

// File: rtl/pulse_shifter.sv
module pulse_shifter #(
    parameter int WIDTH = 8,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] amount,
    input  logic             dir,
    output logic [WIDTH-1:0] result,
    output logic             done,
    output logic             busy
);
    import pulse_shifter_pkg::*;

    logic             accept, run;
    logic             arm_left, arm_right;
    logic             step_left, step_right;
    logic [AMT_W-1:0] cnt_left, cnt_right;
    logic [WIDTH-1:0] word;

    assign arm_left  = accept && (shift_dir_e'(dir) == DIR_LEFT);
    assign arm_right = accept && (shift_dir_e'(dir) == DIR_RIGHT);

    shift_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .any_step (step_left || step_right),
        .word     (word),
        .accept   (accept),
        .run      (run),
        .busy     (busy),
        .done     (done),
        .result   (result)
    );

    step_gen #(.AMT_W(AMT_W)) u_gen_left (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm_left),
        .amt    (amount),
        .enable (run),
        .step   (step_left),
        .count  (cnt_left)
    );

    step_gen #(.AMT_W(AMT_W)) u_gen_right (
        .clk    (clk),
        .rst_n  (rst_n),
        .arm    (arm_right),
        .amt    (amount),
        .enable (run),
        .step   (step_right),
        .count  (cnt_right)
    );

    bidir_shreg #(.WIDTH(WIDTH)) u_shreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .din        (data_in),
        .step_left  (step_left),
        .step_right (step_right),
        .word       (word)
    );

    AST_ONE_GEN: assert property (@(posedge clk) disable iff (!rst_n)
        !((cnt_left != '0) && (cnt_right != '0))); // R10

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done); // R9

    AST_IDLE_COUNTS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |-> ((cnt_left == '0) && (cnt_right == '0))); // R10

endmodule

// File: tb/pulse_shifter_test.sv
`timescale 1ns/1ps
module pulse_shifter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       load = 1'b0;
    logic [7:0] data_in = '0;
    logic [2:0] amount = '0;
    logic       dir = 1'b0;
    logic [7:0] result;
    logic       done;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [7:0] prev_result = '0;

    always #2.5 clk = ~clk;

    pulse_shifter uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .data_in (data_in),
        .amount  (amount),
        .dir     (dir),
        .result  (result),
        .done    (done),
        .busy    (busy)
    );

    function automatic logic [7:0] expect_shift(logic [7:0] d, logic [2:0] n, logic r);
        return r ? (d >> n) : (d << n);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(logic [7:0] d, logic [2:0] n, logic r, bit intrude);
        logic [7:0] exp = expect_shift(d, n, r);
        @(negedge clk);
        load = 1'b1; data_in = d; amount = n; dir = r;
        @(negedge clk);
        load = 1'b0;
        check("R2 busy after load", busy, 1);
        for (int k = 1; k <= n + 1; k++) begin
            if (intrude && k == 1) begin
                load = 1'b1; data_in = ~d; amount = 3'd0; dir = ~r;
            end
            @(negedge clk);
            load = 1'b0;
            if (k <= n) begin
                check("R6 no early done", done, 0);
                check("R8 busy during run", busy, 1);
                if (k == 1) check("R9 result held during run", result, prev_result);
            end else begin
                check("R6 done at N+1", done, 1);
                check("R7 busy low with done", busy, 0);
                if (n == 0) check("R5 zero amount", result, d);
                else if (intrude) check("R8 intruding load ignored", result, exp);
                else if (r) check("R4 right shift", result, exp);
                else check("R3 left shift R10", result, exp);
            end
        end
        @(negedge clk);
        check("R7 done single pulse", done, 0);
        check("R9 result holds", result, exp);
        prev_result = exp;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset result", result, 0);
        check("R1 reset done", done, 0);
        check("R1 reset busy", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        run_op(8'hA5, 3'd0, 1'b0, 0);
        run_op(8'hA5, 3'd0, 1'b1, 0);
        run_op(8'hFF, 3'd7, 1'b0, 0);
        run_op(8'hFF, 3'd7, 1'b1, 0);
        run_op(8'h01, 3'd7, 1'b0, 0);
        run_op(8'h80, 3'd7, 1'b1, 0);
        run_op(8'h3C, 3'd3, 1'b0, 1);
        run_op(8'h3C, 3'd3, 1'b1, 1);
        repeat (4) @(negedge clk);
        check("R9 idle hold", result, prev_result);
        void'($urandom(32'd1234));
        for (int i = 0; i < 200; i++) begin
            run_op(8'($urandom), 3'($urandom), 1'($urandom), ($urandom % 4) == 0);
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule